// File: doc/BRIEF.md
# Clock Loss Monitor Reset

This block watches a system bus clock and requests a system reset when that clock stops or runs too slowly. The clock is judged against a free-running reference clock. In the monitored clock domain a request bit changes state, and a two-flop synchronizer in the reference domain detects each change. The detected value is sent back as an acknowledge, and the monitored side changes the request bit again only after that acknowledge has come through two flops in its own domain. Each completed round trip counts as one event. A stopped monitored clock therefore produces no events and is caught without any logic that depends on it. Because each event waits for the acknowledge, a monitored clock that runs faster than the reference cannot alias into a false reading.

The reference domain counts events inside a window of `WIN_CYC` reference cycles. A window that ends with fewer than `MIN_EVT` events raises the reset request. A round trip costs about three monitored periods plus three reference periods. With a 1 MHz reference, `WIN_CYC = 1024` and `MIN_EVT = 8`, the trip point is near 23 kHz. That lies between the 10 kHz that must trip and the 200 kHz that must pass. The request stays low for a minimum hold time and is then released only by a complete good window. A sticky flag records that the monitor caused a reset, and only power-on reset clears it. The enable bit is assumed synchronous to the reference clock.

Top module: `clk_loss_monitor`

## Requirements
- R1: After `por_n` is released, `rst_req_n` is 1 and `loss_flag` is 0.
- R2: With `mon_en` = 1, a monitored clock whose period is at most 20 reference cycles at default parameters never drives `rst_req_n` low. This includes monitored clocks faster than the reference.
- R3: With `mon_en` = 1, a stopped monitored clock drives `rst_req_n` to 0, the active reset level, at the next window boundary at which a whole window has elapsed without enough events.
- R4: With `mon_en` = 1, a monitored clock with a period of 60 reference cycles or more at default parameters drives `rst_req_n` to 0.
- R5: While `mon_en` = 0, `rst_req_n` is 1 in the same cycle. Clearing `mon_en` also cancels a reset request that is already active.
- R6: Once `rst_req_n` goes low with `mon_en` held at 1, it stays low for `HOLD_CYC` reference cycles. It then rises only at the end of a fresh full window of `WIN_CYC` cycles that saw at least `MIN_EVT` events. If the monitored clock is healthy again before the hold ends, the low time is exactly `HOLD_CYC + WIN_CYC` cycles.
- R7: While `mon_en` = 0 the window and event count are held at zero, so every 0-to-1 change of `mon_en` starts a clean window. Enabling the monitor together with a healthy clock does not cause a reset.
- R8: `loss_flag` becomes 1 in the same cycle that the monitor first asserts its reset request. It stays 1 through release and through changes of `mon_en`, and is cleared only by `por_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Monitored bus clock |
| ref_clk | input | 1 | Independent free-running reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mon_en | input | 1 | Monitor enable, synchronous to `ref_clk` |
| rst_req_n | output | 1 | Reset request to the system, active low |
| loss_flag | output | 1 | Sticky cause flag: the monitor requested a reset |

## Verification
The monitored clock is driven in several regimes:
- faster than the reference, which shows that the handshake does not alias;
- comfortably above the trip point;
- a few times below the trip point;
- far below a whole window;
- fully stopped.

Each regime is also tried with the monitor disabled. These patterns separate a correct counting threshold from counters that pass slow clocks or trip on fast ones.

Directed cases cover the rest:
- Measuring the exact low time after a brief stop separates the hold phase from the fresh-window release.
- Enabling the monitor in the same cycle that a clock appears exposes any stale window state.
- Pulsing power-on reset shows which reset clears the cause flag.

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
  parameter int WIN_CYC  = 1024,
  parameter int MIN_EVT  = 8,
  parameter int HOLD_CYC = 64
) (
  input  logic mon_clk,
  input  logic ref_clk,
  input  logic por_n,
  input  logic mon_en,
  output logic rst_req_n,
  output logic loss_flag
);
  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int EW = $clog2(MIN_EVT + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic          req_q, ack_m1, ack_m2;
  logic          rq_s1, rq_s2, rq_s3;
  logic          evt;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] evt_cnt, evt_nxt;
  logic [HW-1:0] hold_cnt;
  logic          trip_q, holding, win_last, win_ok, trip_set;

  // monitored domain: advance the request once the previous change came back
  always_ff @(posedge mon_clk or negedge por_n)
    if (!por_n) begin
      req_q  <= 1'b0;
      ack_m1 <= 1'b0;
      ack_m2 <= 1'b0;
    end else begin
      ack_m1 <= rq_s3;
      ack_m2 <= ack_m1;
      if (ack_m2 == req_q) req_q <= ~req_q;
    end

  // reference domain: synchronize the request, detect each change
  always_ff @(posedge ref_clk or negedge por_n)
    if (!por_n) {rq_s1, rq_s2, rq_s3} <= '0;
    else        {rq_s1, rq_s2, rq_s3} <= {req_q, rq_s1, rq_s2};

  assign evt      = rq_s2 ^ rq_s3;
  assign holding  = trip_q && (hold_cnt != '0);
  assign win_last = (win_cnt == WW'(WIN_CYC - 1));
  assign evt_nxt  = (evt && evt_cnt != EW'(MIN_EVT)) ? evt_cnt + 1'b1 : evt_cnt;
  assign win_ok   = (evt_nxt == EW'(MIN_EVT));
  assign trip_set = mon_en && win_last && !win_ok && !trip_q;

  always_ff @(posedge ref_clk or negedge por_n)
    if (!por_n) begin
      win_cnt <= '0;
      evt_cnt <= '0;
    end else if (!mon_en || holding || win_last) begin
      win_cnt <= '0;
      evt_cnt <= '0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      evt_cnt <= evt_nxt;
    end

  always_ff @(posedge ref_clk or negedge por_n)
    if (!por_n) begin
      trip_q   <= 1'b0;
      hold_cnt <= '0;
    end else if (!mon_en) begin
      trip_q   <= 1'b0;
      hold_cnt <= '0;
    end else if (holding) begin
      hold_cnt <= hold_cnt - 1'b1;
    end else if (trip_set) begin
      trip_q   <= 1'b1;
      hold_cnt <= HW'(HOLD_CYC);
    end else if (win_last && win_ok) begin
      trip_q   <= 1'b0;
    end

  always_ff @(posedge ref_clk or negedge por_n)
    if (!por_n)        loss_flag <= 1'b0;
    else if (trip_set) loss_flag <= 1'b1;

  assign rst_req_n = ~(trip_q & mon_en);

  // R3
  trip_at_window_end_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    $rose(trip_q) |-> $past(win_last && !win_ok));

  // R6
  hold_low_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    holding && mon_en |=> !rst_req_n || !mon_en);

  // R6
  release_on_good_window_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    mon_en && $past(mon_en) && $rose(rst_req_n) |-> $past(win_last && win_ok));

  // R7
  clean_window_on_enable_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    $rose(mon_en) |-> win_cnt == '0 && evt_cnt == '0);

  // R8
  flag_sticky_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    loss_flag |=> loss_flag);

  // R8
  flag_with_request_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    !rst_req_n |-> loss_flag);

  // R2
  evt_bound_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    evt_cnt <= EW'(MIN_EVT));
endmodule

// File: tb/clk_loss_monitor_bench.sv
`timescale 1ns/1ps
module clk_loss_monitor_bench;
  localparam int WIN  = 1024;
  localparam int MINE = 8;
  localparam int HOLD = 64;
  localparam int NV   = 9;
  // half period of the monitored clock in ns (0 = stopped), enable, expected outputs
  localparam int V_HALF [NV] = '{25, 0, 50, 150, 150, 0, 2, 5000, 10};
  localparam bit V_EN   [NV] = '{1, 1, 1, 1, 0, 0, 1, 1, 1};
  localparam bit V_RST  [NV] = '{1, 0, 1, 0, 1, 1, 1, 0, 1};
  localparam bit V_FLAG [NV] = '{0, 1, 1, 1, 1, 1, 1, 1, 1};

  logic ref_clk = 1'b0, mon_clk = 1'b0, por_n = 1'b0, mon_en = 1'b0;
  logic rst_req_n, loss_flag;
  int   mon_half = 0;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  clk_loss_monitor #(.WIN_CYC(WIN), .MIN_EVT(MINE), .HOLD_CYC(HOLD)) u_clk_loss_monitor (
    .mon_clk(mon_clk), .ref_clk(ref_clk), .por_n(por_n), .mon_en(mon_en),
    .rst_req_n(rst_req_n), .loss_flag(loss_flag));

  always #2.5 ref_clk = ~ref_clk;

  always begin
    if (mon_half == 0) begin mon_clk = 1'b0; #5; end
    else begin #(mon_half); mon_clk = ~mon_clk; end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic string vec_req(input int i);
    if (!V_EN[i])       return "R5";
    else if (V_RST[i])  return "R2";
    else if (V_HALF[i] == 0) return "R3";
    else                return "R4";
  endfunction

  task automatic wait_low(input int limit);
    for (int k = 0; k < limit && rst_req_n; k++) @(negedge ref_clk);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int low_cnt;
    int bad;
    repeat (4) @(negedge ref_clk);
    por_n = 1'b1;
    @(negedge ref_clk);
    chk("R1 rst_req_n", rst_req_n, 1'b1);
    chk("R1 loss_flag", loss_flag, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge ref_clk);
      mon_half = V_HALF[i];
      mon_en   = V_EN[i];
      repeat (4 * WIN + HOLD) @(negedge ref_clk);
      chk(vec_req(i), rst_req_n, V_RST[i]);
      chk("R8", loss_flag, V_FLAG[i]);
    end

    // R6: brief stop, then healthy clock before the hold ends
    mon_half = 10;
    repeat (2 * WIN) @(negedge ref_clk);
    mon_half = 0;
    wait_low(3 * WIN);
    mon_half = 10;
    low_cnt = 0;
    for (int k = 0; k < 4000 && !rst_req_n; k++) begin
      low_cnt++;
      @(negedge ref_clk);
    end
    checks++;
    if (low_cnt < HOLD + WIN || low_cnt > HOLD + WIN + 4) begin
      fails++;
      $display("FAIL R6: got low for %0d cycles expected %0d", low_cnt, HOLD + WIN);
    end

    // R5: clearing the enable cancels an active request at once
    mon_half = 0;
    wait_low(3 * WIN);
    chk("R3 stop trips", rst_req_n, 1'b0);
    mon_en = 1'b0;
    #1;
    chk("R5 abort", rst_req_n, 1'b1);
    chk("R8 flag kept", loss_flag, 1'b1);

    // R7: enable together with a clock appearing, no low cycle allowed
    repeat (3 * WIN) @(negedge ref_clk);
    mon_half = 10;
    mon_en   = 1'b1;
    bad = 0;
    for (int k = 0; k < 3 * WIN; k++) begin
      @(negedge ref_clk);
      if (!rst_req_n) bad++;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R7: got %0d low cycles expected 0", bad);
    end

    // R8 / R1: only power-on reset clears the flag
    chk("R8 flag before por", loss_flag, 1'b1);
    por_n = 1'b0;
    @(negedge ref_clk);
    chk("R8 flag cleared by por", loss_flag, 1'b0);
    por_n = 1'b1;
    repeat (2) @(negedge ref_clk);
    chk("R1 rst after por", rst_req_n, 1'b1);
    chk("R1 flag after por", loss_flag, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule